// File: doc/BRIEF.md
# Programmable Core Clock Divider Controller

This block sets how fast a processor core runs. It takes one fixed, high-rate PLL clock and produces a single-cycle core clock-enable pulse. The pulse fires once every 2^N PLL cycles. N is a 3-bit field in an 8-bit control register, so the core rate runs from the full PLL rate (N=0) down to one 128th of it (N=7). With the PLL at 512 times a 32.768 kHz reference (16.777216 MHz), this gives core rates from 16.777216 MHz down to 131.072 kHz. No derived clock net is created: everything stays in the PLL clock domain, and the core logic qualifies its flops with `core_ce`.

The control register sits at one address on a synchronous write/read port. Its fields are as follows:
- **Bits [2:0]:** the divide select.
- **Bit 3:** the fast-interrupt enable.
- **Bit 6:** a lock flag that mirrors the PLL tracking status. It is read-only.
- **Bit 7:** the low-frequency oscillator power-down control.
- **Bits 5 and 4:** reserved, always 0.

The register resets to 0x03, so the core starts at the PLL rate divided by 8.

When the fast-interrupt enable is set and at least one interrupt is being serviced, the core runs at the full PLL rate. A nesting counter tracks interrupt entry and return strobes, and the programmed rate comes back once the nesting depth returns to zero. A change of divisor, or a change into or out of full speed, is taken only at an enable-pulse boundary. This means no core cycle is ever cut short or merged with the next.

The pulse generator has two states:
- **`RATE_DIV`:** a period lasts 2^N cycles.
- **`RATE_FAST`:** every cycle is a boundary.

It has two transitions, both taken only at a boundary:
- **boost-on:** `RATE_DIV` to `RATE_FAST`, when the fast-interrupt enable is set and the nesting depth is nonzero.
- **boost-off:** `RATE_FAST` to `RATE_DIV`, when that condition no longer holds.

The nesting tracker also has two states:
- **`NEST_IDLE`:** the depth is 0.
- **`NEST_ACTIVE`:** the depth is nonzero.

Its transitions are:
- **first-entry:** `NEST_IDLE` to `NEST_ACTIVE`, on an entry strobe without a return strobe.
- **last-return:** `NEST_ACTIVE` to `NEST_IDLE`, on a return strobe at depth 1.

Top module: `core_clk_ctrl`

## Requirements
- R1: While reset is asserted, `core_ce` is low. After release, the first pulse appears in the eighth cycle (the release cycle counts as the first). Pulses then repeat every 8 cycles, and the register reads 0x03 with the lock bit merged in.
- R2: With bits [2:0] = N and no boost active, consecutive `core_ce` pulses are exactly 2^N PLL cycles apart, for every N from 0 to 7.
- R3: For N ≥ 1 with no boost active, `core_ce` is high for exactly one cycle per period.
- R4: Bit 6 of the readback equals `pll_locked` as sampled in the read cycle. Writes to bit 6 are ignored.
- R5: Bits 5 and 4 of the readback are always 0, whatever was written.
- R6: Bits 7, 3 and 2:0 store the written value and read back unchanged. The readback image is {bit7, lock, 0, 0, bit3, bits[2:0]}.
- R7: With bit 3 set and the nesting depth nonzero, `core_ce` is high on every cycle from the first boundary after entry.
- R8: After the last interrupt return, the period in progress ends at the next cycle. Pulses then resume 2^N cycles apart.
- R9: With bit 3 clear, interrupt entry does not change the pulse spacing.
- R10: A divisor written during a period takes effect only after that period ends at its old length. This includes a write landing in the pulse cycle itself.
- R11: Each entry strobe raises the nesting depth and each return lowers it, so full speed holds until every entry has been matched by a return. Entry and return in the same cycle leave the depth unchanged, and a return at depth 0 is ignored.
- R12: The register decodes at address 0xD7 only. Writes elsewhere are ignored. `reg_rdata` is registered: one cycle after a read at 0xD7 it holds the image, and it is 0x00 after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pll | input | 1 | Fixed-rate PLL clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| pll_locked | input | 1 | PLL tracking status |
| irq_enter | input | 1 | Interrupt entry strobe, one cycle |
| irq_return | input | 1 | Interrupt return strobe, one cycle |
| core_ce | output | 1 | Core clock-enable pulse |
| reg_rdata | output | 8 | Registered readback data |

## Verification
A register write that changes the divide select can land in the same cycle as an enable-pulse boundary. At that edge the boundary latches the old select, while the register takes the new value.

The bench provokes this by issuing a write at the very cycle a pulse is observed, then measuring the next two gaps. The first gap must still be the old period and only the second the new one.

A mid-period write is measured the same way for contrast. Entry and return strobes raised together are also provoked, and judged by the pulse spacing staying unchanged.

// File: rtl/ccd_pkg.sv
package ccd_pkg;

    // Width of the divide-select field; divisor is 2**sel.
    localparam int SEL_W = 3;
    // Period counter must reach 2**(2**SEL_W - 1) - 1.
    localparam int CNT_W = (1 << SEL_W) - 1;
    // Reset image of the control register.
    localparam logic [7:0] RESET_VALUE = 8'h03;

    typedef enum logic {
        RATE_DIV,
        RATE_FAST
    } rate_state_t;

    typedef enum logic {
        NEST_IDLE,
        NEST_ACTIVE
    } nest_state_t;

    typedef struct packed {
        logic             osc_pd;
        logic             fast_irq_en;
        logic [SEL_W-1:0] div_sel;
    } ctrl_fields_t;

endpackage

// File: rtl/ccd_ctrl_reg.sv
module ccd_ctrl_reg
    import ccd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 'hD7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              pll_locked,
    output ctrl_fields_t      fields,
    output logic [7:0]        rdata
);

    logic       hit;
    logic [7:0] image;

    always_comb begin
        hit   = (addr == ADDR_W'(REG_ADDR));
        // Lock bit is live, reserved bits are hard zero.
        image = {fields.osc_pd, pll_locked, 2'b00, fields.fast_irq_en, fields.div_sel};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fields.osc_pd      <= RESET_VALUE[7];
            fields.fast_irq_en <= RESET_VALUE[3];
            fields.div_sel     <= RESET_VALUE[SEL_W-1:0];
        end else if (wr_en && hit) begin
            fields.osc_pd      <= wdata[7];
            fields.fast_irq_en <= wdata[3];
            fields.div_sel     <= wdata[SEL_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= 8'h00;
        end else begin
            rdata <= (rd_en && hit) ? image : 8'h00;
        end
    end

endmodule

// File: rtl/ccd_irq_nest.sv
module ccd_irq_nest
    import ccd_pkg::*;
#(
    parameter int DEPTH_W = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enter,
    input  logic leave,
    output logic active
);

    localparam logic [DEPTH_W-1:0] DEPTH_MAX = '1;
    localparam logic [DEPTH_W-1:0] DEPTH_ONE = DEPTH_W'(1);

    nest_state_t        state_q, state_d;
    logic [DEPTH_W-1:0] depth_q, depth_d;

    // Next-state and depth update.
    always_comb begin
        state_d = state_q;
        depth_d = depth_q;
        unique case (state_q)
            NEST_IDLE: begin
                // first-entry
                if (enter && !leave) begin
                    depth_d = DEPTH_ONE;
                    state_d = NEST_ACTIVE;
                end
            end
            NEST_ACTIVE: begin
                if (enter && !leave) begin
                    if (depth_q != DEPTH_MAX) begin
                        depth_d = depth_q + DEPTH_ONE;
                    end
                end else if (leave && !enter) begin
                    depth_d = depth_q - DEPTH_ONE;
                    // last-return
                    if (depth_q == DEPTH_ONE) begin
                        state_d = NEST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= NEST_IDLE;
            depth_q <= '0;
        end else begin
            state_q <= state_d;
            depth_q <= depth_d;
        end
    end

    always_comb begin
        active = (state_q == NEST_ACTIVE);
    end

endmodule

// File: rtl/ccd_rate_gen.sv
module ccd_rate_gen
    import ccd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] div_sel,
    input  logic             boost,
    output logic             core_ce
);

    rate_state_t      state_q, state_d;
    logic [SEL_W-1:0] sel_q, sel_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [SEL_W-1:0] shift;
    logic [CNT_W-1:0] limit;
    logic             at_bound;

    // Period length in use: full rate when boosted, else the latched select.
    always_comb begin
        shift    = (state_q == RATE_FAST) ? '0 : sel_q;
        limit    = {CNT_W{1'b1}} >> (CNT_W - int'(shift));
        at_bound = (cnt_q == limit);
    end

    // Rate and select change only at a period boundary.
    always_comb begin
        state_d = state_q;
        sel_d   = sel_q;
        cnt_d   = cnt_q + 1'b1;
        if (at_bound) begin
            cnt_d = '0;
            sel_d = div_sel;
            unique case (state_q)
                RATE_DIV:  if (boost)  state_d = RATE_FAST;  // boost-on
                RATE_FAST: if (!boost) state_d = RATE_DIV;   // boost-off
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RATE_DIV;
            sel_q   <= RESET_VALUE[SEL_W-1:0];
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            sel_q   <= sel_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        core_ce = at_bound;
    end

endmodule

// File: rtl/core_clk_ctrl.sv
module core_clk_ctrl
    import ccd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 'hD7,
    parameter int          DEPTH_W  = 3
) (
    input  logic              clk_pll,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic              reg_rd_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              pll_locked,
    input  logic              irq_enter,
    input  logic              irq_return,
    output logic              core_ce,
    output logic [7:0]        reg_rdata
);

    ctrl_fields_t     fields;
    logic [SEL_W-1:0] div_sel;
    logic             nest_active;
    logic             boost;

    ccd_ctrl_reg #(
        .ADDR_W  (ADDR_W),
        .REG_ADDR(REG_ADDR)
    ) u_reg (
        .clk       (clk_pll),
        .rst_n     (rst_n),
        .wr_en     (reg_wr_en),
        .rd_en     (reg_rd_en),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .pll_locked(pll_locked),
        .fields    (fields),
        .rdata     (reg_rdata)
    );

    ccd_irq_nest #(
        .DEPTH_W(DEPTH_W)
    ) u_nest (
        .clk   (clk_pll),
        .rst_n (rst_n),
        .enter (irq_enter),
        .leave (irq_return),
        .active(nest_active)
    );

    always_comb begin
        div_sel = fields.div_sel;
        boost   = fields.fast_irq_en && nest_active;
    end

    ccd_rate_gen u_rate (
        .clk    (clk_pll),
        .rst_n  (rst_n),
        .div_sel(div_sel),
        .boost  (boost),
        .core_ce(core_ce)
    );

endmodule

// File: rtl/ccd_checker.sv
module ccd_checker
    import ccd_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter int unsigned REG_ADDR = 'hD7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_rd_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_rdata,
    input logic              pll_locked,
    input logic              irq_enter,
    input logic              irq_return,
    input logic              core_ce,
    input logic              boost,
    input logic [SEL_W-1:0]  div_sel,
    input logic              nest_active
);

    logic rd_hit;
    always_comb rd_hit = reg_rd_en && (reg_addr == ADDR_W'(REG_ADDR));

    assert_rsv_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rdata[5:4] == 2'b00);

    assert_lock_mirror_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |=> reg_rdata[6] == $past(pll_locked));

    assert_miss_reads_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> reg_rdata == 8'h00);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ce && !boost && div_sel != '0) |=> !core_ce);

    assert_fast_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (core_ce && boost) |=> core_ce);

    assert_nest_pair_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!nest_active && irq_enter && irq_return) |=> !nest_active);

endmodule

bind core_clk_ctrl ccd_checker #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR)
) u_chk (
    .clk        (clk_pll),
    .rst_n      (rst_n),
    .reg_rd_en  (reg_rd_en),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .pll_locked (pll_locked),
    .irq_enter  (irq_enter),
    .irq_return (irq_return),
    .core_ce    (core_ce),
    .boost      (boost),
    .div_sel    (div_sel),
    .nest_active(nest_active)
);

// File: tb/core_clk_ctrl_bench.sv
module core_clk_ctrl_bench;

    localparam logic [7:0] A_REG = 8'hD7;
    localparam int WATCHDOG = 150000;

    logic       clk_pll = 1'b0;
    logic       rst_n;
    logic       reg_wr_en, reg_rd_en;
    logic [7:0] reg_addr, reg_wdata;
    logic       pll_locked;
    logic       irq_enter, irq_return;
    logic       core_ce;
    logic [7:0] reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk_pll = ~clk_pll;

    core_clk_ctrl u_core_clk_ctrl (
        .clk_pll   (clk_pll),
        .rst_n     (rst_n),
        .reg_wr_en (reg_wr_en),
        .reg_rd_en (reg_rd_en),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pll_locked(pll_locked),
        .irq_enter (irq_enter),
        .irq_return(irq_return),
        .core_ce   (core_ce),
        .reg_rdata (reg_rdata)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] image(input logic [7:0] w, input logic lock);
        return {w[7], lock, 2'b00, w[3], w[2:0]};
    endfunction

    // All drive tasks start and end at a falling edge.
    task automatic write_reg(input logic [7:0] a, input logic [7:0] d);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk_pll);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_reg(input logic [7:0] a, output logic [7:0] d);
        reg_rd_en = 1'b1; reg_addr = a;
        @(negedge clk_pll);
        reg_rd_en = 1'b0;
        d = reg_rdata;
    endtask

    task automatic irq_pulse(input logic e, input logic r);
        irq_enter = e; irq_return = r;
        @(negedge clk_pll);
        irq_enter = 1'b0; irq_return = 1'b0;
    endtask

    // Cycles until the next observed pulse.
    task automatic next_pulse(output int g);
        g = 0;
        do begin
            @(negedge clk_pll);
            g++;
        end while (!core_ce && g < 400);
    endtask

    task automatic t_reset();
        int g;
        logic [7:0] d;
        rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
        pll_locked = 1'b1; irq_enter = 0; irq_return = 0;
        repeat (4) @(negedge clk_pll);
        check_eq("R1", "core_ce in reset", int'(core_ce), 0);
        rst_n = 1'b1;
        next_pulse(g);
        check_eq("R1", "first pulse cycle after release", g, 7);
        next_pulse(g);
        check_eq("R1", "reset period", g, 8);
        read_reg(A_REG, d);
        check_eq("R1", "reset readback", int'(d), int'(image(8'h03, 1'b1)));
    endtask

    task automatic t_regs();
        logic [7:0] d;
        write_reg(A_REG, 8'hFF);
        read_reg(A_REG, d);
        check_eq("R5", "reserved bits after 0xFF", int'(d), 8'hCF);
        pll_locked = 1'b0;
        read_reg(A_REG, d);
        check_eq("R4", "lock bit follows input", int'(d), 8'h8F);
        write_reg(A_REG, 8'h40);
        read_reg(A_REG, d);
        check_eq("R4", "write to lock bit ignored", int'(d), 8'h00);
        write_reg(A_REG, 8'h8A);
        read_reg(A_REG, d);
        check_eq("R6", "stored fields", int'(d), int'(image(8'h8A, 1'b0)));
        write_reg(8'hD6, 8'h05);
        read_reg(A_REG, d);
        check_eq("R12", "write at other address ignored", int'(d), 8'h8A);
        read_reg(8'hD6, d);
        check_eq("R12", "read at other address", int'(d), 8'h00);
        pll_locked = 1'b1;
        read_reg(A_REG, d);
        check_eq("R4", "lock bit set again", int'(d), 8'hCA);
    endtask

    task automatic t_ratios();
        int g;
        for (int n = 0; n < 8; n++) begin
            write_reg(A_REG, 8'(n));
            next_pulse(g);
            next_pulse(g);
            check_eq("R2", $sformatf("gap for select %0d", n), g, 1 << n);
            if (n > 0) begin
                @(negedge clk_pll);
                check_eq("R3", $sformatf("pulse width select %0d", n), int'(core_ce), 0);
            end
        end
    endtask

    task automatic t_boundary();
        int g;
        write_reg(A_REG, 8'h02);
        next_pulse(g);
        next_pulse(g);
        // Write lands in the pulse cycle itself.
        write_reg(A_REG, 8'h05);
        next_pulse(g);
        check_eq("R10", "coincident write keeps old period", g + 1, 4);
        next_pulse(g);
        check_eq("R10", "new period after coincident write", g, 32);
        repeat (3) @(negedge clk_pll);
        write_reg(A_REG, 8'h01);
        next_pulse(g);
        check_eq("R10", "mid-period write keeps old period", g + 4, 32);
        next_pulse(g);
        check_eq("R10", "new period after mid write", g, 2);
    endtask

    task automatic t_fast();
        int g;
        int hi;
        write_reg(A_REG, 8'h0D);
        next_pulse(g);
        next_pulse(g);
        repeat (5) @(negedge clk_pll);
        irq_pulse(1'b1, 1'b0);
        next_pulse(g);
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_pll);
            hi += int'(core_ce);
        end
        check_eq("R7", "pulses while boosted", hi, 6);
        irq_pulse(1'b0, 1'b1);
        next_pulse(g);
        check_eq("R8", "first period after return", g, 32);
        next_pulse(g);
        check_eq("R8", "steady period after return", g, 32);
    endtask

    task automatic t_nest();
        int g;
        int hi;
        irq_pulse(1'b1, 1'b0);
        irq_pulse(1'b1, 1'b0);
        next_pulse(g);
        irq_pulse(1'b0, 1'b1);
        hi = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk_pll);
            hi += int'(core_ce);
        end
        check_eq("R11", "still fast at depth one", hi, 6);
        irq_pulse(1'b0, 1'b1);
        next_pulse(g);
        check_eq("R11", "slow after last return", g, 32);
        irq_pulse(1'b1, 1'b1);
        next_pulse(g);
        next_pulse(g);
        check_eq("R11", "same-cycle entry and return", g, 32);
        irq_pulse(1'b0, 1'b1);
        next_pulse(g);
        next_pulse(g);
        check_eq("R11", "return at depth zero ignored", g, 32);
    endtask

    task automatic t_fint_off();
        int g;
        write_reg(A_REG, 8'h05);
        next_pulse(g);
        irq_pulse(1'b1, 1'b0);
        next_pulse(g);
        next_pulse(g);
        check_eq("R9", "no boost with enable clear", g, 32);
        irq_pulse(1'b0, 1'b1);
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    endtask

    initial begin
        @(negedge clk_pll);
        t_reset();
        t_regs();
        t_ratios();
        t_boundary();
        t_fast();
        t_nest();
        t_fint_off();
        done = 1'b1;
        report();
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk_pll);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all requirements actual=%0d expected=done", WATCHDOG);
            report();
            $finish;
        end
    end

endmodule